// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block sequences a 10-bit successive-approximation converter from the CPU clock. A 7-bit prescaler divides the CPU clock into ADC clock periods. It emits a rising-phase tick and a falling-phase tick in each period. The sequencer places the sample-and-hold instant on those ticks and then resolves one result bit per ADC clock, starting with the MSB. It drives the trial code to the external DAC and reads back one comparator decision per bit. At the end it writes the result register and raises a completion flag. The analog parts (DAC, comparator, reference and input selection) stay outside; one comparator input stands for all of them.

A conversion is started by a software request or, in auto-trigger mode, by a rising edge on a trigger input. A software request waits for the next ADC clock rise. A synchronised trigger edge restarts the prescaler, so the delay from trigger to sample is always the same. The first conversion after enable rises is a long one. A conversion is also long every time when differential mode is combined with auto-trigger.

Top module: `adc_seq`

## Requirements
- R1: After reset, busy, done_flag, sh_strobe, bit_step and adc_tick are 0 and result is 0.
- R2: While enable is high, adc_tick pulses once every N CPU cycles. N is 2, 2, 4, 8, 16, 32, 64 or 128 for div_sel codes 0 to 7. While enable is low, adc_tick never pulses.
- R3: A start_req pulse seen while idle makes busy read 1 from the next cycle on. The conversion begins in the first cycle after the request in which adc_tick is 1 (cycle B). For a normal conversion, sh_strobe pulses in cycle B + 3N/2.
- R4: A normal conversion raises done_flag in cycle B + 13N + 1. The first conversion after enable rises samples at B + 27N/2 and raises done_flag at B + 25N + 1. The result register changes only when a conversion completes.
- R5: busy stays 1 from the request until completion and falls in the same cycle that done_flag is set, unless enable drops first.
- R6: After the sample, exactly 10 bit_step pulses resolve the bits MSB first. Each trial code appears on dac_code. A bit is kept when cmp_in is 1 and cleared when it is 0, so an input V with cmp_in = (dac_code <= V) yields result = V.
- R7: done_flag stays set until a cycle with flag_clr high, and clears in the cycle after that one.
- R8: start_req and trigger edges that arrive while busy is 1 are ignored. No further conversion follows the one in progress.
- R9: With auto_trig high and enable high, a trig_in rising edge first sampled at clock edge c+1 (input driven in cycle c) is synchronised into cycle E = c+2. The edge restarts the prescaler. sh_strobe pulses in cycle E + 2N and done_flag rises at E + L·N + 1, where L is the conversion length in ADC cycles.
- R10: With diff_mode and auto_trig both high, every conversion is long (L = 25), whether it is the first or not.
- R11: Dropping enable aborts a conversion in progress: busy reads 0 in the next cycle. The next conversion is a long first conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; low holds the prescaler in reset |
| div_sel | input | 3 | Prescaler division select |
| start_req | input | 1 | One-cycle software start request |
| auto_trig | input | 1 | Auto-trigger mode enable |
| trig_in | input | 1 | Asynchronous trigger source |
| diff_mode | input | 1 | Differential mode select |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above dac_code |
| flag_clr | input | 1 | Write-one clear of the completion flag |
| busy | output | 1 | Start bit readback; 1 while pending or converting |
| adc_tick | output | 1 | ADC clock rising-phase tick |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| bit_step | output | 1 | Successive-approximation bit strobe |
| dac_code | output | 10 | Current trial code for the DAC |
| result | output | 10 | Conversion result register |
| done_flag | output | 1 | Completion flag |

## Verification
On every cycle, the assertions check several invariants. No ADC tick appears while the block is disabled. busy falls only together with a completion or an abort. done_flag clears only after a clear request. result moves only when a conversion ends. The strobes appear only inside a busy window and never together. The exact cycle positions can only be shown by the bench's scenarios, which measure them against the start tick or trigger edge for each division. Those positions are the 1.5- and 13.5-cycle sample points, the fixed trigger-to-sample delay, and the 13- and 25-cycle lengths. The scenarios also show the resolved codes for chosen input values and the long conversion forced after enable or in differential auto-trigger.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int RES_W      = 10;
    localparam int PRESC_W    = 7;
    localparam int SEL_W      = 3;
    localparam int NORM_LEN   = 13;
    localparam int FIRST_LEN  = 25;
    // sample points counted in half ADC cycles from conversion start
    localparam int NORM_SH_H  = 3;
    localparam int FIRST_SH_H = 27;
    localparam int TRIG_SH_H  = 4;
    localparam int HCNT_W     = $clog2(2 * FIRST_LEN + 1);
    localparam int LEFT_W     = $clog2(RES_W + 1);

    typedef struct packed {
        logic               pend;
        logic               conv;
        logic               trig;
        logic               long_c;
        logic               first;
        logic [HCNT_W-1:0]  hcnt;
        logic [LEFT_W-1:0]  left;
        logic [RES_W-1:0]   trial;
        logic [RES_W-1:0]   result;
        logic               flag;
    } seq_state_t;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
    parameter int PRESC_W = 7,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             rise,
    output logic             fall
);
    logic [PRESC_W-1:0] cnt_d, cnt_q;
    logic [PRESC_W-1:0] mask;
    logic [SEL_W-1:0]   shamt;

    always_comb begin
        shamt = (sel == '0) ? SEL_W'(1) : sel;
        mask  = ~({PRESC_W{1'b1}} << shamt);
        cnt_d = (!run || clr) ? '0 : cnt_q + 1'b1;
        rise  = run && ((cnt_q & mask) == mask);
        fall  = run && ((cnt_q & mask) == (mask >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_edge
);
    logic [STAGES:0] sync_d, sync_q;

    always_comb begin
        sync_d    = {sync_q[STAGES-1:0], trig_async};
        trig_edge = sync_q[STAGES-1] & ~sync_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             start_req,
    input  logic             auto_trig,
    input  logic             trig_in,
    input  logic             diff_mode,
    input  logic             cmp_in,
    input  logic             flag_clr,
    output logic             busy,
    output logic             adc_tick,
    output logic             sh_strobe,
    output logic             bit_step,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             done_flag
);
    localparam logic [HCNT_W-1:0] NORM_LIM  = HCNT_W'(2 * NORM_LEN - 1);
    localparam logic [HCNT_W-1:0] FIRST_LIM = HCNT_W'(2 * FIRST_LEN - 1);

    seq_state_t d, q;
    logic rise, fall, half, trig_edge, trig_go, sw_go, fin;
    logic [HCNT_W-1:0] hs;
    logic [LEFT_W-1:0] idx;

    adc_prescaler #(.PRESC_W(PRESC_W), .SEL_W(SEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(enable), .clr(trig_go),
        .sel(div_sel), .rise(rise), .fall(fall)
    );

    adc_trig_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .trig_async(trig_in), .trig_edge(trig_edge)
    );

    always_comb begin
        half      = rise | fall;
        busy      = q.pend | q.conv;
        hs        = q.trig ? HCNT_W'(TRIG_SH_H) : (q.long_c ? HCNT_W'(FIRST_SH_H) : HCNT_W'(NORM_SH_H));
        trig_go   = auto_trig && enable && !busy && trig_edge;
        sw_go     = q.pend && rise;
        sh_strobe = q.conv && half && (q.hcnt == hs - 1'b1);
        bit_step  = q.conv && rise && (q.left != '0) && (q.hcnt >= hs);
        fin       = q.conv && half && (q.hcnt == (q.long_c ? FIRST_LIM : NORM_LIM));
        idx       = q.left - 1'b1;

        d = q;
        if (flag_clr) d.flag = 1'b0;
        if (!enable) begin
            d.pend  = 1'b0;
            d.conv  = 1'b0;
            d.first = 1'b1;
        end else if (sw_go || trig_go) begin
            d.pend   = 1'b0;
            d.conv   = 1'b1;
            d.trig   = trig_go;
            d.long_c = q.first || (diff_mode && auto_trig);
            d.first  = 1'b0;
            d.hcnt   = '0;
            d.left   = '0;
            d.trial  = '0;
        end else if (q.conv) begin
            if (half) d.hcnt = q.hcnt + 1'b1;
            if (sh_strobe) begin
                d.trial = RES_W'(1) << (RES_W - 1);
                d.left  = LEFT_W'(RES_W);
            end
            if (bit_step) begin
                if (!cmp_in) d.trial[idx] = 1'b0;
                if (idx != '0) d.trial[idx - 1'b1] = 1'b1;
                d.left = idx;
            end
            if (fin) begin
                d.conv   = 1'b0;
                d.result = q.trial;
                d.flag   = 1'b1;
            end
        end else if (start_req) begin
            d.pend = 1'b1;
        end

        adc_tick  = rise;
        dac_code  = q.trial;
        result    = q.result;
        done_flag = q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.first <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             flag_clr,
    input logic             busy,
    input logic             adc_tick,
    input logic             sh_strobe,
    input logic             bit_step,
    input logic [RES_W-1:0] result,
    input logic             done_flag
);
    // R2
    tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !adc_tick);
    // R5
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(enable)) |-> done_flag);
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_flag) |-> $past(flag_clr));
    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy));
    // R6
    step_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_step || sh_strobe) |-> busy);
    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_step && sh_strobe));
endmodule

bind adc_seq adc_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flag_clr(flag_clr),
    .busy(busy), .adc_tick(adc_tick), .sh_strobe(sh_strobe),
    .bit_step(bit_step), .result(result), .done_flag(done_flag)
);

// File: tb/adc_seq_test.sv
`timescale 1ns/1ps
module adc_seq_test;
    logic clk = 0, rst_n = 0;
    logic enable = 0, start_req = 0, auto_trig = 0, trig_in = 0, diff_mode = 0, flag_clr = 0;
    logic [2:0] div_sel = 0;
    logic [9:0] model_v = 0;
    logic cmp_in, busy, adc_tick, sh_strobe, bit_step, done_flag;
    logic [9:0] dac_code, result;
    int cyc = 0, checks = 0, fails = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign cmp_in = (dac_code <= model_v);

    adc_seq uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
        .start_req(start_req), .auto_trig(auto_trig), .trig_in(trig_in),
        .diff_mode(diff_mode), .cmp_in(cmp_in), .flag_clr(flag_clr),
        .busy(busy), .adc_tick(adc_tick), .sh_strobe(sh_strobe),
        .bit_step(bit_step), .dac_code(dac_code), .result(result),
        .done_flag(done_flag)
    );

    // {sel[15:13], fresh[12], diff[11], auto[10], value[9:0]}
    localparam logic [15:0] VEC [8] = '{
        {3'd0, 1'b1, 1'b0, 1'b0, 10'h2A5},
        {3'd0, 1'b0, 1'b0, 1'b0, 10'h000},
        {3'd2, 1'b0, 1'b0, 1'b0, 10'h3FF},
        {3'd3, 1'b0, 1'b0, 1'b1, 10'h155},
        {3'd1, 1'b0, 1'b1, 1'b1, 10'h0F0},
        {3'd4, 1'b1, 1'b0, 1'b1, 10'h201},
        {3'd1, 1'b0, 1'b1, 1'b0, 10'h3C3},
        {3'd7, 1'b0, 1'b0, 1'b0, 10'h07E}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_conv(input logic [2:0] sel, input bit fresh, input bit first_exp,
                           input bit diff, input bit aut, input logic [9:0] v);
        int n, c, base, shc, donec, steps, len, hs;
        bit lng;
        @(negedge clk);
        div_sel = sel; diff_mode = diff; auto_trig = aut; model_v = v; flag_clr = 1;
        if (fresh) enable = 0;
        @(negedge clk);
        flag_clr = 0; enable = 1;
        repeat (3) @(negedge clk);
        n   = 1 << ((sel == 0) ? 1 : int'(sel));
        lng = first_exp || (diff && aut);
        len = lng ? 25 : 13;
        hs  = aut ? 4 : (lng ? 27 : 3);
        c = cyc;
        if (aut) trig_in = 1; else start_req = 1;
        base = aut ? c + 2 : -1;
        shc = -1; donec = -1; steps = 0;
        for (int k = 0; k < 8000 && donec < 0; k++) begin
            @(negedge clk);
            start_req = 0; trig_in = 0;
            if (k == 0 && !aut) chk(busy == 1, "R3 busy after request", busy, 1);
            if (!aut && base < 0 && adc_tick) base = cyc;
            if (sh_strobe && shc < 0) shc = cyc;
            if (bit_step) steps++;
            if (done_flag) begin
                donec = cyc;
                chk(busy == 0, "R5 busy clears with flag", busy, 0);
            end
        end
        if (aut) chk(shc == base + hs * n / 2, "R9 trigger to sample", shc - base, hs * n / 2);
        else if (lng) chk(shc == base + hs * n / 2, "R4 first sample point", shc - base, hs * n / 2);
        else chk(shc == base + hs * n / 2, "R3 normal sample point", shc - base, hs * n / 2);
        if (diff && aut) chk(donec == base + len * n + 1, "R10 long diff conversion", donec - base, len * n + 1);
        else chk(donec == base + len * n + 1, "R4 conversion length", donec - base, len * n + 1);
        chk(steps == 10, "R6 bit step count", steps, 10);
        chk(result == v, "R6 resolved code", int'(result), int'(v));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int t1, t2, t3, cnt, cs;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done_flag == 0, "R1 reset flags", {busy, done_flag}, 0);
        chk(result == 0 && sh_strobe == 0 && bit_step == 0, "R1 reset outputs", int'(result), 0);
        rst_n = 1;
        @(negedge clk);
        chk(adc_tick == 0 && busy == 0, "R1 idle after reset", {adc_tick, busy}, 0);

        // R2: disabled prescaler never ticks
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (adc_tick) cnt++;
        end
        chk(cnt == 0, "R2 no tick while disabled", cnt, 0);

        // R2: tick spacing per code
        enable = 1;
        for (int s = 0; s < 8; s++) begin
            div_sel = 3'(s);
            t1 = -1; t2 = -1; t3 = -1;
            for (int k = 0; k < 1000 && t3 < 0; k++) begin
                @(negedge clk);
                if (adc_tick) begin
                    if (t1 < 0) t1 = cyc;
                    else if (t2 < 0) t2 = cyc;
                    else t3 = cyc;
                end
            end
            chk(t3 - t2 == (1 << ((s == 0) ? 1 : s)), "R2 tick period", t3 - t2, 1 << ((s == 0) ? 1 : s));
        end

        // vector table: R3 R4 R6 R9 R10
        foreach (VEC[i])
            do_conv(VEC[i][15:13], VEC[i][12], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9:0]);

        // R7: flag holds, then clears on request
        repeat (10) @(negedge clk);
        chk(done_flag == 1, "R7 flag held", done_flag, 1);
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
        chk(done_flag == 0, "R7 flag cleared", done_flag, 0);

        // R8: second start during conversion is ignored
        div_sel = 0; auto_trig = 0; diff_mode = 0; model_v = 10'h111;
        start_req = 1;
        @(negedge clk);
        start_req = 0;
        repeat (6) @(negedge clk);
        start_req = 1;
        @(negedge clk);
        start_req = 0;
        for (int k = 0; k < 200 && !done_flag; k++) @(negedge clk);
        chk(done_flag == 1, "R8 first conversion completes", done_flag, 1);
        cs = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (busy || sh_strobe) cs++;
        end
        chk(cs == 0, "R8 ignored start leaves idle", cs, 0);

        // R8: trigger during a triggered conversion is ignored
        auto_trig = 1; flag_clr = 1;
        @(negedge clk);
        flag_clr = 0; trig_in = 1;
        @(negedge clk);
        trig_in = 0;
        repeat (10) @(negedge clk);
        trig_in = 1;
        @(negedge clk);
        trig_in = 0;
        for (int k = 0; k < 200 && !done_flag; k++) @(negedge clk);
        cs = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (busy || sh_strobe) cs++;
        end
        chk(cs == 0, "R8 ignored trigger leaves idle", cs, 0);
        auto_trig = 0;

        // R11: abort by disable, then a long conversion follows
        start_req = 1;
        @(negedge clk);
        start_req = 0;
        repeat (8) @(negedge clk);
        chk(busy == 1, "R11 busy before abort", busy, 1);
        enable = 0;
        @(negedge clk);
        chk(busy == 0, "R11 busy after abort", busy, 0);
        do_conv(3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 10'h19C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule